// File: doc/BRIEF.md
# Taken-Branch Fall-Through Resume Buffer

This block lives in the instruction fetch path. When the predictor calls a branch taken, fetch needs a cycle to form the target address and start fetching from it. During that window the sequential instruction groups that follow the branch are already at hand, and this block keeps them instead of dropping them. Each held group carries the program counter of its first instruction.

The branch is identified by a tag. Only one such branch is tracked at a time, and a second taken prediction made while one is pending is ignored. When the branch resolves, the block acts on the outcome:

- If the taken call was right, the held groups are thrown away.
- If the branch was in fact not taken, the block sends the held groups out again, oldest first. Fetch restarts from saved instructions rather than waiting on the instruction cache, which saves a cycle.

Capture and replay are valid/ready streams. A group is taken in only on a cycle where `cap_valid` and `cap_ready` are both high. While `cap_ready` is low, offered groups are not stored, so the source may drop them or hold them. Replay follows the same rule. While `rp_valid` is high and `rp_ready` is low, the current group and its PC stay unchanged, and the block advances only on a handshake. Arming and resolution are plain one-cycle strobes.

Top module: `mispredict_resume_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cap_ready`, `rp_valid` and `rp_done` are low.
- R2: `cap_ready` is high only while a branch is pending and fewer than DEPTH groups are held. A group offered while `cap_ready` is low is not stored and never appears on replay.
- R3: An `arm_valid` strobe while a branch is already pending has no effect. The pending tag is kept and the held groups are untouched.
- R4: A resolve strobe whose `res_id` differs from the pending tag has no effect.
- R5: A resolve with the matching tag and `res_mispredict` low discards all held groups. No replay follows, and a later branch starts from an empty buffer.
- R6: A resolve with the matching tag and `res_mispredict` high starts replay. `rp_valid` rises on the cycle after the strobe, and the held groups come out one per handshake in capture order, each with the PC it was captured with.
- R7: While `rp_valid` is high and `rp_ready` is low, `rp_valid`, `rp_group` and `rp_pc` hold their values on the next cycle.
- R8: `rp_done` is high for exactly one cycle. That cycle is the one after the last replay handshake, or the one after the resolve strobe when no group was held. `rp_valid` is low while `rp_done` is high.
- R9: At most DEPTH groups are held. After DEPTH captures `cap_ready` stays low until the branch resolves.
- R10: A group accepted in the same cycle as a mispredicting resolve is included as the last group of the replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Taken prediction strobe, opens tracking of a branch |
| arm_id | input | ID_W | Tag of the branch predicted taken |
| cap_valid | input | 1 | Fall-through group offered |
| cap_ready | output | 1 | Block accepts a fall-through group this cycle |
| cap_group | input | LANES*INSTR_W | Instruction group, lane 0 in the low bits |
| cap_pc | input | PC_W | PC of the group's first instruction |
| res_valid | input | 1 | Branch resolution strobe |
| res_mispredict | input | 1 | High when the resolved branch was not taken |
| res_id | input | ID_W | Tag of the resolved branch |
| rp_valid | output | 1 | Replay group available |
| rp_ready | input | 1 | Fetch takes the replay group |
| rp_group | output | LANES*INSTR_W | Replayed instruction group |
| rp_pc | output | PC_W | PC of the replayed group |
| rp_done | output | 1 | One-cycle pulse after replay ends |

## Verification
The bench uses the default parameters: DEPTH 4, LANES 4, INSTR_W 32, PC_W 32 and ID_W 4. With four slots the full-buffer refusal and a four-group replay are both short enough to drive directly. The 4-bit tag leaves room for distinct stale, duplicate and matching tags. The bench also runs a replay under alternating back-pressure so that stalls fall on both middle and final groups.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    RB_IDLE   = 2'd0,
    RB_ARMED  = 2'd1,
    RB_REPLAY = 2'd2,
    RB_DONE   = 2'd3
  } rb_state_e;
endpackage

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 160,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             rd_adv,
  output logic [CNT_W-1:0] count,
  output logic [ENT_W-1:0] rd_data,
  output logic             rd_last,
  output logic             full
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wr_sel;
  logic [IDX_W-1:0] rd_ptr;

  // one write strobe per slot, chosen by the fill level
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (count == CNT_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_sel[i]) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      count  <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en && !full) count  <= count + CNT_W'(1);
      if (rd_adv)         rd_ptr <= rd_ptr + IDX_W'(1);
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CNT_W'(DEPTH));
  assign rd_last = ((CNT_W'(rd_ptr) + CNT_W'(1)) == count);
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_valid,
  input  logic [ID_W-1:0]  arm_id,
  input  logic             res_valid,
  input  logic             res_mispredict,
  input  logic [ID_W-1:0]  res_id,
  input  logic             cap_fire,
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic             rd_last,
  input  logic             rp_ready,
  output logic             cap_ready,
  output logic             rp_valid,
  output logic             rp_done,
  output logic             st_clr,
  output logic             st_adv
);
  rb_state_e         state, nxt;
  logic [ID_W-1:0]   pend_id;
  logic              take_arm;
  logic              hit;

  assign take_arm = arm_valid && (state == RB_IDLE || state == RB_DONE);
  assign hit      = res_valid && (res_id == pend_id) && (state == RB_ARMED);

  always_comb begin
    nxt    = state;
    st_clr = 1'b0;
    st_adv = 1'b0;
    unique case (state)
      RB_IDLE, RB_DONE: begin
        if (arm_valid) begin
          nxt    = RB_ARMED;
          st_clr = 1'b1;
        end else begin
          nxt = RB_IDLE;
        end
      end
      RB_ARMED: begin
        if (hit) begin
          if (res_mispredict) begin
            // a capture landing this same cycle still counts
            nxt = ((count == '0) && !cap_fire) ? RB_DONE : RB_REPLAY;
          end else begin
            nxt    = RB_IDLE;
            st_clr = 1'b1;
          end
        end
      end
      RB_REPLAY: begin
        if (rp_ready) begin
          if (rd_last) nxt = RB_DONE;
          else         st_adv = 1'b1;
        end
      end
      default: nxt = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RB_IDLE;
      pend_id <= '0;
    end else begin
      state <= nxt;
      if (take_arm) pend_id <= arm_id;
    end
  end

  assign cap_ready = (state == RB_ARMED) && !full;
  assign rp_valid  = (state == RB_REPLAY);
  assign rp_done   = (state == RB_DONE);
endmodule

// File: rtl/mispredict_resume_buf.sv
module mispredict_resume_buf #(
  parameter int DEPTH   = 4,
  parameter int LANES   = 4,
  parameter int INSTR_W = 32,
  parameter int PC_W    = 32,
  parameter int ID_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm_valid,
  input  logic [ID_W-1:0]          arm_id,
  input  logic                     cap_valid,
  output logic                     cap_ready,
  input  logic [LANES*INSTR_W-1:0] cap_group,
  input  logic [PC_W-1:0]          cap_pc,
  input  logic                     res_valid,
  input  logic                     res_mispredict,
  input  logic [ID_W-1:0]          res_id,
  output logic                     rp_valid,
  input  logic                     rp_ready,
  output logic [LANES*INSTR_W-1:0] rp_group,
  output logic [PC_W-1:0]          rp_pc,
  output logic                     rp_done
);
  localparam int GRP_W = LANES * INSTR_W;
  localparam int ENT_W = GRP_W + PC_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             cap_fire;
  logic             st_clr, st_adv, st_full, st_last;
  logic [CNT_W-1:0] st_count;
  logic [ENT_W-1:0] st_rd;

  assign cap_fire = cap_valid && cap_ready;

  rb_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_clr),
    .wr_en   (cap_fire),
    .wr_data ({cap_pc, cap_group}),
    .rd_adv  (st_adv),
    .count   (st_count),
    .rd_data (st_rd),
    .rd_last (st_last),
    .full    (st_full)
  );

  rb_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm_valid      (arm_valid),
    .arm_id         (arm_id),
    .res_valid      (res_valid),
    .res_mispredict (res_mispredict),
    .res_id         (res_id),
    .cap_fire       (cap_fire),
    .count          (st_count),
    .full           (st_full),
    .rd_last        (st_last),
    .rp_ready       (rp_ready),
    .cap_ready      (cap_ready),
    .rp_valid       (rp_valid),
    .rp_done        (rp_done),
    .st_clr         (st_clr),
    .st_adv         (st_adv)
  );

  assign rp_group = st_rd[GRP_W-1:0];
  assign rp_pc    = st_rd[ENT_W-1:GRP_W];
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int GRP_W = 128,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_ready,
  input logic             res_valid,
  input logic             res_mispredict,
  input logic             rp_valid,
  input logic             rp_ready,
  input logic [GRP_W-1:0] rp_group,
  input logic [PC_W-1:0]  rp_pc,
  input logic             rp_done
);
  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!rp_valid && !rp_done && !cap_ready));

  // R2
  capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready |-> (!rp_valid && !rp_done));

  // R6
  replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rp_valid) |-> $past(res_valid && res_mispredict));

  // R7
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_valid && !rp_ready) |=> (rp_valid && $stable(rp_group) && $stable(rp_pc)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_done |=> !rp_done);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_done |-> !rp_valid);
endmodule

bind mispredict_resume_buf rb_checker #(.GRP_W(LANES*INSTR_W), .PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cap_ready      (cap_ready),
  .res_valid      (res_valid),
  .res_mispredict (res_mispredict),
  .rp_valid       (rp_valid),
  .rp_ready       (rp_ready),
  .rp_group       (rp_group),
  .rp_pc          (rp_pc),
  .rp_done        (rp_done)
);

// File: tb/tb_mispredict_resume_buf.sv
`timescale 1ns/1ps
module tb_mispredict_resume_buf;
  localparam int GRP_W = 128;
  localparam int PC_W  = 32;
  localparam int ID_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid = 1'b0;
  logic [ID_W-1:0] arm_id = '0;
  logic cap_valid = 1'b0;
  logic cap_ready;
  logic [GRP_W-1:0] cap_group = '0;
  logic [PC_W-1:0] cap_pc = '0;
  logic res_valid = 1'b0, res_mispredict = 1'b0;
  logic [ID_W-1:0] res_id = '0;
  logic rp_valid, rp_done;
  logic rp_ready = 1'b1;
  logic [GRP_W-1:0] rp_group;
  logic [PC_W-1:0] rp_pc;

  int total = 0, bad = 0, done_cnt = 0;
  bit bp_mode = 1'b0;
  bit finished = 1'b0;
  logic [PC_W+GRP_W-1:0] sb[$];

  always #5 clk = ~clk;

  mispredict_resume_buf dut (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_id(arm_id),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_group(cap_group), .cap_pc(cap_pc),
    .res_valid(res_valid), .res_mispredict(res_mispredict), .res_id(res_id),
    .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_group(rp_group), .rp_pc(rp_pc),
    .rp_done(rp_done)
  );

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [GRP_W-1:0] mk(input int s);
    return {32'(s * 16 + 3), 32'(s * 16 + 2), 32'(s * 16 + 1), 32'(s * 16)};
  endfunction

  // back-pressure driver for the replay side
  initial forever begin
    @(posedge clk); #1;
    rp_ready = bp_mode ? ~rp_ready : 1'b1;
  end

  // monitor: compares replayed groups against the scoreboard
  logic stall_prev = 1'b0;
  logic [GRP_W-1:0] prev_g;
  logic [PC_W-1:0] prev_pc;
  always @(negedge clk) if (rst_n) begin
    if (rp_valid && stall_prev)
      chk(rp_group == prev_g && rp_pc == prev_pc,
          $sformatf("R7 held group changed act=%h/%h exp=%h/%h", rp_pc, rp_group, prev_pc, prev_g));
    if (rp_valid && rp_ready) begin
      if (sb.size() == 0) chk(1'b0, $sformatf("R6 unexpected replay act=%h exp=none", rp_pc));
      else begin
        logic [PC_W+GRP_W-1:0] e;
        e = sb.pop_front();
        chk({rp_pc, rp_group} == e,
            $sformatf("R6 replay order act=%h exp=%h", {rp_pc, rp_group}, e));
      end
    end
    if (rp_done) done_cnt++;
    stall_prev = rp_valid && !rp_ready;
    prev_g = rp_group;
    prev_pc = rp_pc;
  end

  // driver tasks: entered at posedge+1, leave at posedge+1
  task automatic arm(input int id);
    arm_valid = 1'b1; arm_id = ID_W'(id);
    @(posedge clk); #1 arm_valid = 1'b0;
  endtask

  task automatic cap(input int s, input bit exp_rdy, input string req);
    bit r;
    cap_valid = 1'b1; cap_group = mk(s); cap_pc = 32'h1000 + 32'(s * 16);
    @(negedge clk); r = cap_ready;
    chk(r == exp_rdy, $sformatf("%s cap_ready act=%0d exp=%0d", req, r, exp_rdy));
    if (r) sb.push_back({cap_pc, cap_group});
    @(posedge clk); #1 cap_valid = 1'b0;
  endtask

  task automatic resolve(input int id, input bit mis);
    res_valid = 1'b1; res_id = ID_W'(id); res_mispredict = mis;
    @(posedge clk); #1 res_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0, input string req);
    for (int i = 0; i < 40 && done_cnt == d0; i++) @(posedge clk);
    @(posedge clk); #1;
    chk(done_cnt == d0 + 1, $sformatf("%s done pulses act=%0d exp=%0d", req, done_cnt - d0, 1));
    chk(sb.size() == 0, $sformatf("%s groups left act=%0d exp=0", req, sb.size()));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d0;
    #12;
    chk(!cap_ready && !rp_valid && !rp_done,
        $sformatf("R1 reset outputs act=%0d%0d%0d exp=000", cap_ready, rp_valid, rp_done));
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!cap_ready && !rp_valid && !rp_done, "R1 after release act=nonzero exp=000");

    // R2: offer while idle is refused
    cap(90, 1'b0, "R2");

    // R6/R8: two groups, mispredict, replay with ready held high
    arm(3);
    cap(1, 1'b1, "R2"); cap(2, 1'b1, "R2");
    d0 = done_cnt;
    resolve(3, 1'b1);
    @(negedge clk);
    chk(rp_valid, $sformatf("R6 first valid act=%0d exp=1", rp_valid));
    @(posedge clk); #1;
    wait_done(d0, "R8");

    // R9/R3/R4: fill four, extra refused, stray arm and tag ignored
    arm(5);
    cap(10, 1'b1, "R9"); cap(11, 1'b1, "R9"); cap(12, 1'b1, "R9"); cap(13, 1'b1, "R9");
    cap(14, 1'b0, "R9");
    arm(6);
    resolve(6, 1'b1);
    @(negedge clk);
    chk(!rp_valid && !rp_done, $sformatf("R4 stale tag act=%0d%0d exp=00", rp_valid, rp_done));
    chk(!cap_ready, $sformatf("R3 still full act=%0d exp=0", cap_ready));
    @(posedge clk); #1;
    // R7: replay under alternating back-pressure
    bp_mode = 1'b1;
    d0 = done_cnt;
    resolve(5, 1'b1);
    wait_done(d0, "R7");
    bp_mode = 1'b0;
    @(posedge clk); #1;

    // R5: correct prediction discards, later branch starts empty
    arm(7);
    cap(20, 1'b1, "R5"); cap(21, 1'b1, "R5"); cap(22, 1'b1, "R5");
    d0 = done_cnt;
    resolve(7, 1'b0);
    sb.delete();
    repeat (4) @(posedge clk); #1;
    chk(done_cnt == d0 && !rp_valid, $sformatf("R5 no replay act=%0d exp=0", done_cnt - d0));
    arm(8);
    resolve(8, 1'b1);
    @(negedge clk);
    chk(rp_done && !rp_valid, $sformatf("R8 empty done act=%0d%0d exp=10", rp_done, rp_valid));
    @(posedge clk); #1;
    @(negedge clk);
    chk(!rp_done, $sformatf("R8 pulse width act=%0d exp=0", rp_done));
    chk(sb.size() == 0, $sformatf("R5 leftovers act=%0d exp=0", sb.size()));
    @(posedge clk); #1;

    // R10: capture on the same cycle as the mispredict resolve
    arm(9);
    cap(30, 1'b1, "R10");
    d0 = done_cnt;
    res_valid = 1'b1; res_id = 4'd9; res_mispredict = 1'b1;
    cap(31, 1'b1, "R10");
    res_valid = 1'b0;
    wait_done(d0, "R10");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule